// File: doc/BRIEF.md
# Digital LDO Segment Shift Controller

This block is the clocked control core of an all-digital linear regulator. On every edge of the sampling clock it captures a one-bit comparator decision, which says whether the regulated output sits above or below its reference, together with a gain setting. On the following edge it moves a thermometer code of power-transistor enables. The code moves down when the output is high and up when it is low. The number of positions it moves in one cycle equals the gain setting.

The thermometer code drives the gates of the pass-transistor segments, lowest index first. The block also reports the number of active segments. The code is held in groups of bits, and each group has its own clock enable. A group is clocked only in a cycle where the code boundary can cross it. An integration flow can map these enables onto clock gates, so idle parts of the shifter draw no clock power. The comparator, transistor array, load and output capacitor live outside this block.

Top module: `dldo_seg_ctrl`

## Requirements
- R1: While reset is asserted and right after it, the active count equals parameter INIT_CNT (default 0), the enables hold exactly that many ones, and every group clock enable is low.
- R2: The enable vector is always a thermometer code. Bit i (bit 0 is the least significant) is 1 exactly when i is below the active count.
- R3: A comparator input of 1 (output above reference) lowers the active count. A comparator input of 0 raises it.
- R4: The count moves by the unsigned gain value sampled with the decision. A gain of 0 leaves the code unchanged.
- R5: Inputs sampled on clock edge k change the code and the count on edge k+1 and not before.
- R6: An upward move past SEGS (default 128) stops at SEGS and does not wrap.
- R7: A downward move past 0 stops at 0 and does not wrap.
- R8: Group g (bits g*GW to g*GW+GW-1, with GW = SEGS/GROUPS = 16) has its clock enable high exactly when the next count differs from the present count and g is within one of the boundary group. The boundary group is the active count divided by GW, limited to GROUPS-1.
- R9: A group whose clock enable is low in a cycle keeps its enable bits across the next edge.
- R10: The active-count output always equals the number of ones in the enable vector.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmp_hi | input | 1 | Comparator decision, 1 when the output is above the reference |
| gain | input | GAIN_W (4) | Shift step per cycle, 0 to 15 |
| seg_en | output | SEGS (128) | Thermometer enables for the pass-transistor segments |
| active_cnt | output | CNT_W (8) | Number of enabled segments |
| grp_clk_en | output | GROUPS (8) | Clock enable for each group of GW segments |

## Verification
The hardest cases to reach are a large step that lands on a rail, and a boundary that crosses from one group into the next. In both, the group enables and the clamping must agree with each other. The stimulus first ramps up to full scale at maximum gain and keeps pushing there. It then ramps down to zero the same way. After that it runs a long stretch driven by a pseudo-random sequence, with mixed gains and directions. This stretch reaches the boundary at many group edges, including counts that sit exactly on a multiple of the group width. Gain-zero periods and reversals of direction check the hold and the one-cycle decision delay.

// File: rtl/dldo_pkg.sv
package dldo_pkg;
    // Shift direction: comparator reports the output high -> remove segments
    typedef enum logic {
        DIR_UP = 1'b0,
        DIR_DN = 1'b1
    } dir_e;
endpackage

// File: rtl/dldo_cnt_step.sv
// Saturating next-count computation for the segment thermometer.
module dldo_cnt_step #(
    parameter int SEGS   = 128,
    parameter int GAIN_W = 4,
    parameter int CNT_W  = 8
) (
    input  logic [CNT_W-1:0]  cnt_q,
    input  dldo_pkg::dir_e    dir,
    input  logic [GAIN_W-1:0] step,
    output logic [CNT_W-1:0]  cnt_d
);
    localparam logic [CNT_W:0] LIMIT_W = (CNT_W+1)'(SEGS);

    logic [CNT_W:0]   sum_w;
    logic [CNT_W-1:0] step_w;

    always_comb begin
        step_w = CNT_W'(step);
        sum_w  = {1'b0, cnt_q} + {1'b0, step_w};
        if (dir == dldo_pkg::DIR_DN) begin
            // clamp at zero (R7)
            if (step_w >= cnt_q) cnt_d = '0;
            else                 cnt_d = cnt_q - step_w;
        end else begin
            // clamp at full scale (R6)
            if (sum_w > LIMIT_W) cnt_d = LIMIT_W[CNT_W-1:0];
            else                 cnt_d = sum_w[CNT_W-1:0];
        end
    end
endmodule

// File: rtl/dldo_grp_gate.sv
// Per-group clock enables: only groups that the boundary can reach tick.
module dldo_grp_gate #(
    parameter int SEGS   = 128,
    parameter int GROUPS = 8,
    parameter int CNT_W  = 8
) (
    input  logic [CNT_W-1:0]  cnt_q,
    input  logic              move,
    output logic [GROUPS-1:0] grp_en
);
    localparam int GW = SEGS / GROUPS;

    int bnd_grp;

    always_comb begin
        bnd_grp = int'(cnt_q) / GW;
        if (bnd_grp > GROUPS - 1) bnd_grp = GROUPS - 1;
        for (int g = 0; g < GROUPS; g++) begin
            grp_en[g] = move && (g + 1 >= bnd_grp) && (g <= bnd_grp + 1);
        end
    end
endmodule

// File: rtl/dldo_seg_group.sv
// One clock-gated slice of the thermometer shifter.
module dldo_seg_group #(
    parameter int GW       = 16,
    parameter int BASE     = 0,
    parameter int CNT_W    = 8,
    parameter int INIT_CNT = 0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic [CNT_W-1:0] cnt_d,
    output logic [GW-1:0]    bits_q
);
    logic [GW-1:0] bits_d;
    logic [GW-1:0] bits_rst;

    always_comb begin
        for (int j = 0; j < GW; j++) begin
            bits_d[j]   = (BASE + j) < int'(cnt_d);
            bits_rst[j] = (BASE + j) < INIT_CNT;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)  bits_q <= bits_rst;
        else if (en) bits_q <= bits_d;
    end

    // The gate must never block a bit that has to change.
    assert_gate_safe_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !en |-> (bits_d == bits_q))
        else $error("group %0d gated while its bits change", BASE / GW);
endmodule

// File: rtl/dldo_seg_ctrl.sv
// Top: comparator sample stage, count register, gated thermometer groups.
module dldo_seg_ctrl #(
    parameter int SEGS     = 128,
    parameter int GROUPS   = 8,
    parameter int GAIN_W   = 4,
    parameter int INIT_CNT = 0,
    localparam int CNT_W   = $clog2(SEGS + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmp_hi,
    input  logic [GAIN_W-1:0] gain,
    output logic [SEGS-1:0]   seg_en,
    output logic [CNT_W-1:0]  active_cnt,
    output logic [GROUPS-1:0] grp_clk_en
);
    import dldo_pkg::*;

    localparam int GW = SEGS / GROUPS;
    // A step must not jump past the neighbouring group: 2**GAIN_W-1 <= GW.

    typedef struct packed {
        dir_e              dir;
        logic [GAIN_W-1:0] step;
        logic [CNT_W-1:0]  cnt;
    } st_t;

    st_t st_d, st_q;
    logic [CNT_W-1:0] cnt_nx;
    logic             move;

    dldo_cnt_step #(.SEGS(SEGS), .GAIN_W(GAIN_W), .CNT_W(CNT_W)) step_i (
        .cnt_q (st_q.cnt),
        .dir   (st_q.dir),
        .step  (st_q.step),
        .cnt_d (cnt_nx)
    );

    always_comb begin
        move      = (cnt_nx != st_q.cnt);
        st_d      = st_q;
        st_d.dir  = cmp_hi ? DIR_DN : DIR_UP;   // sampled this edge
        st_d.step = gain;
        st_d.cnt  = cnt_nx;                     // acts on last edge's sample
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.dir  <= DIR_UP;
            st_q.step <= '0;
            st_q.cnt  <= CNT_W'(INIT_CNT);
        end else begin
            st_q <= st_d;
        end
    end

    dldo_grp_gate #(.SEGS(SEGS), .GROUPS(GROUPS), .CNT_W(CNT_W)) gate_i (
        .cnt_q  (st_q.cnt),
        .move   (move),
        .grp_en (grp_clk_en)
    );

    for (genvar g = 0; g < GROUPS; g++) begin : g_grp
        dldo_seg_group #(.GW(GW), .BASE(g * GW), .CNT_W(CNT_W), .INIT_CNT(INIT_CNT)) grp_i (
            .clk    (clk),
            .rst_n  (rst_n),
            .en     (grp_clk_en[g]),
            .cnt_d  (cnt_nx),
            .bits_q (seg_en[g*GW +: GW])
        );
    end

    assign active_cnt = st_q.cnt;

    assert_popcount_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(seg_en) == int'(active_cnt))
        else $error("segment count mismatch");

    assert_thermo_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ((seg_en + SEGS'(1)) & seg_en) == '0)
        else $error("enables not a thermometer code");

    assert_hold_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.step == '0) |=> $stable(seg_en))
        else $error("code moved with zero gain");

    assert_top_clamp_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(active_cnt) == SEGS && st_q.dir == DIR_UP) |=> (int'(active_cnt) == SEGS))
        else $error("count left full scale on an up move");

    assert_bottom_clamp_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (active_cnt == '0 && st_q.dir == DIR_DN) |=> (active_cnt == '0))
        else $error("count left zero on a down move");
endmodule

// File: tb/dldo_seg_ctrl_tb_top.sv
module dldo_seg_ctrl_tb_top;
    localparam int SEGS   = 128;
    localparam int GROUPS = 8;
    localparam int GW     = SEGS / GROUPS;
    localparam int GAIN_W = 4;
    localparam int CNT_W  = $clog2(SEGS + 1);

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              cmp_hi = 1'b0;
    logic [GAIN_W-1:0] gain = '0;
    logic [SEGS-1:0]   seg_en;
    logic [CNT_W-1:0]  active_cnt;
    logic [GROUPS-1:0] grp_clk_en;

    always #2 clk = ~clk;   // 250 MHz

    dldo_seg_ctrl #(.SEGS(SEGS), .GROUPS(GROUPS), .GAIN_W(GAIN_W)) dut_i (
        .clk(clk), .rst_n(rst_n), .cmp_hi(cmp_hi), .gain(gain),
        .seg_en(seg_en), .active_cnt(active_cnt), .grp_clk_en(grp_clk_en)
    );

    typedef struct {
        int               cnt;
        logic [GROUPS-1:0] grp;
    } exp_t;

    exp_t exp_q[$];
    int   n_chk = 0;
    int   n_err = 0;
    bit   done = 0;

    // model state
    int m_cnt = 0;
    bit m_sdn = 0;
    int m_sstep = 0;
    bit cur_dn = 0;
    int cur_g = 0;

    function automatic int nxt(int c, bit dn, int s);
        if (dn) return (s >= c) ? 0 : c - s;
        return (c + s > SEGS) ? SEGS : c + s;
    endfunction

    function automatic logic [GROUPS-1:0] grp_model(int c, bit dn, int s);
        logic [GROUPS-1:0] r;
        int bg;
        bg = c / GW;
        if (bg > GROUPS - 1) bg = GROUPS - 1;
        for (int g = 0; g < GROUPS; g++)
            r[g] = (nxt(c, dn, s) != c) && (g + 1 >= bg) && (g <= bg + 1);
        return r;
    endfunction

    function automatic logic [SEGS-1:0] thermo(int c);
        logic [SEGS-1:0] r;
        for (int i = 0; i < SEGS; i++) r[i] = (i < c);
        return r;
    endfunction

    task automatic check(bit ok, string req, string what, longint act, longint exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    endtask

    // driver: model the edge that just passed, push expectation, drive inputs
    task automatic drive(bit dn, int g);
        exp_t e;
        @(negedge clk);
        m_cnt   = nxt(m_cnt, m_sdn, m_sstep);
        m_sdn   = cur_dn;
        m_sstep = cur_g;
        e.cnt = m_cnt;
        e.grp = grp_model(m_cnt, m_sdn, m_sstep);
        exp_q.push_back(e);
        cmp_hi = dn;
        gain   = GAIN_W'(g);
        cur_dn = dn;
        cur_g  = g;
    endtask

    // monitor: compare outputs just after each falling edge
    initial begin
        logic [SEGS-1:0]   prev_seg;
        logic [GROUPS-1:0] prev_grp;
        bit have_prev;
        exp_t e;
        have_prev = 0;
        prev_seg = '0;
        prev_grp = '0;
        forever begin
            @(negedge clk);
            #1;
            if (exp_q.size() != 0) begin
                e = exp_q.pop_front();
                check(int'(active_cnt) == e.cnt, "R3 R4 R5", "count", active_cnt, e.cnt);
                check(seg_en == thermo(e.cnt), "R2", "thermometer count", $countones(seg_en), e.cnt);
                check(grp_clk_en == e.grp, "R8", "group enables", grp_clk_en, e.grp);
                check($countones(seg_en) == int'(active_cnt), "R10", "ones vs count",
                      $countones(seg_en), active_cnt);
                if (have_prev) begin
                    for (int g = 0; g < GROUPS; g++)
                        if (!prev_grp[g])
                            check(seg_en[g*GW +: GW] == prev_seg[g*GW +: GW], "R9",
                                  "gated group bits", seg_en[g*GW +: GW], prev_seg[g*GW +: GW]);
                end
                prev_seg = seg_en;
                prev_grp = grp_clk_en;
                have_prev = 1;
            end
        end
    end

    // watchdog
    initial begin
        repeat (100000) @(posedge clk);
        n_err++;
        n_chk++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        summary();
    end

    initial begin
        logic [15:0] lf;
        repeat (3) @(posedge clk);
        #1;
        // R1: state under reset
        check(active_cnt == '0, "R1", "count in reset", active_cnt, 0);
        check(seg_en == '0, "R1", "enables in reset", $countones(seg_en), 0);
        check(grp_clk_en == '0, "R1", "group enables in reset", grp_clk_en, 0);
        @(negedge clk);
        rst_n = 1'b1;
        // R1: first cycle after release, nothing sampled yet
        drive(0, 0);
        // R5: one move up of 5, then reverse; first edge must not move
        drive(0, 5);
        drive(1, 3);
        #1;
        check(active_cnt == '0, "R5", "no move before second edge", active_cnt, 0);
        drive(1, 3);
        #1;
        check(int'(active_cnt) == 5, "R5", "move after second edge", active_cnt, 5);
        drive(0, 0);
        drive(0, 0);
        drive(0, 0);
        // R6: ramp to the top at maximum gain and keep pushing
        for (int i = 0; i < 14; i++) drive(0, 15);
        drive(0, 0);
        #1;
        check(int'(active_cnt) == SEGS, "R6", "clamp at full scale", active_cnt, SEGS);
        drive(0, 0);
        // R7: ramp to the bottom
        for (int i = 0; i < 14; i++) drive(1, 15);
        drive(1, 0);
        #1;
        check(active_cnt == '0, "R7", "clamp at zero", active_cnt, 0);
        // single steps across a group edge
        for (int i = 0; i < 20; i++) drive(0, 1);
        for (int i = 0; i < 6; i++) drive(1, 2);
        // pseudo-random mix
        lf = 16'hACE1;
        for (int i = 0; i < 600; i++) begin
            lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
            drive(lf[0] ^ (m_cnt > 100) & lf[5], int'(lf[4:1]));
        end
        for (int i = 0; i < 3; i++) drive(0, 0);
        repeat (2) @(negedge clk);
        #2;
        done = 1;
        summary();
    end
endmodule